// File: doc/BRIEF.md
# Console Control Scan Sequencer

This block captures a snapshot of one mixing-console channel's control settings. A channel carries 32 switch contacts and 16 rider potentiometers. The switches are sensed eight at a time through an external selector. Each pot voltage is routed through an external analog multiplexer to an 8-bit converter, which has 256 positions. Every switch group and every pot owns one slot in a 20-entry map. Slots 0 to 3 hold switch groups 0 to 3. Slots 4 to 19 hold pots 0 to 15.

A one-cycle start request launches a walk through all 20 slots. A switch group is stored in the same cycle its selector is driven. A pot slot first drives the multiplexer select and waits out a settling count given by the host. It then sends a one-cycle conversion start to the converter and stalls until the converter answers with done and data. The scan is meant for snapshot storage, not for continuous control. The host reads the map through a plain address and data port at any time, including while a scan is in progress.

Top module: `console_scan_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `adc_start_o` are low, and every map slot reads 0.
- R2: A `start_i` seen while idle raises `busy_o` on the next cycle. `busy_o` stays high until the scan ends. `adc_start_o` never rises while `busy_o` is low.
- R3: Switch group g (g = 0..3) is the 8-bit value on `sw_data_i` while `sw_grp_sel_o` equals g. It is stored in slot g, and bit b of the slot is switch 8g+b. The groups are scanned in order 0, 1, 2, 3, one per cycle.
- R4: Pot k (k = 0..15) is stored in slot 4+k. The stored value is the `adc_data_i` that accompanies `adc_done_i` while `pot_sel_o` equals k.
- R5: With `settle_i` = S, `pot_sel_o` is held for S+1 cycles before `adc_start_o` is raised. For pot 0, exactly S+5 cycles pass with `busy_o` high and `adc_start_o` low before the first conversion start.
- R6: `adc_start_o` is a single-cycle pulse. It fires exactly 16 times per scan, once per pot.
- R7: While a conversion is pending, the scan waits for `adc_done_i` for any number of cycles. `pot_sel_o` stays unchanged during that wait.
- R8: `done_o` is a one-cycle pulse in the cycle after the last pot is stored. `busy_o` is already low in that cycle.
- R9: `rd_data_o` shows slot `rd_addr_i` combinationally. A slot being rewritten in the current cycle still reads its previous value, and the new value appears the cycle after. Slots not yet rescanned keep the previous scan's value.
- R10: A `start_i` that arrives while `busy_o` is high is ignored. The scan finishes once, and no new scan follows.
- R11: Reading an address of 20 or higher returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Scan request, acted on only when idle |
| settle_i | input | 8 | Settling cycles after each pot select, minus one |
| sw_grp_sel_o | output | 2 | Switch group select |
| sw_data_i | input | 8 | Selected switch group contents |
| pot_sel_o | output | 4 | Analog multiplexer channel select |
| adc_start_o | output | 1 | Conversion start pulse |
| adc_done_i | input | 1 | Conversion complete strobe |
| adc_data_i | input | 8 | Conversion result, valid with done |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Scan complete pulse |
| rd_addr_i | input | 5 | Host read address |
| rd_data_o | output | 8 | Host read data |

## Verification
The host read port and the scan's write into the same slot can land in the same cycle. The bench provokes this by holding the read address on slot 0 while issuing a start. In the cycle where group 0 is being stored, it expects the previous snapshot's value, and one cycle later it expects the new one. The bench also keeps reading a pot slot that has not yet been rescanned, and expects that slot to hold its old value while the scan is still running.

// File: rtl/ctl_scan_pkg.sv
package ctl_scan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SWITCH = 2'd1,
        ST_SETTLE = 2'd2,
        ST_CONV   = 2'd3
    } scan_state_e;

    localparam int DEF_GROUPS   = 4;
    localparam int DEF_POTS     = 16;
    localparam int DEF_DATA_W   = 8;
    localparam int DEF_SETTLE_W = 8;

endpackage

// File: rtl/scan_settle_timer.sv
module scan_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = load_val_i;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign zero_o = (tmr_q.cnt == '0);

    // R5: once expired, the counter rests at zero until reloaded
    assert_settle_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);

    // R5: a load with a nonzero value starts a countdown
    assert_settle_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i != '0) |=> !zero_o);

endmodule

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
    import ctl_scan_pkg::*;
#(
    parameter int N_GRP   = 4,
    parameter int N_POT   = 16,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 5,
    parameter int GSEL_W  = 2,
    parameter int PSEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] sw_data_i,
    input  logic              adc_done_i,
    input  logic [DATA_W-1:0] adc_data_i,
    input  logic              settle_zero_i,
    output logic              settle_load_o,
    output logic [GSEL_W-1:0] grp_sel_o,
    output logic [PSEL_W-1:0] pot_sel_o,
    output logic              adc_start_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);

    localparam logic [ADDR_W-1:0] LAST_GRP_A  = ADDR_W'(N_GRP - 1);
    localparam logic [ADDR_W-1:0] LAST_SLOT_A = ADDR_W'(N_GRP + N_POT - 1);

    typedef struct packed {
        scan_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [GSEL_W-1:0] gsel;
        logic [PSEL_W-1:0] psel;
        logic              adc_start;
        logic              done;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d           = fsm_q;
        fsm_d.adc_start = 1'b0;
        fsm_d.done      = 1'b0;
        settle_load_o   = 1'b0;
        wr_en_o         = 1'b0;
        wr_data_o       = sw_data_i;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    fsm_d.st   = ST_SWITCH;
                    fsm_d.addr = '0;
                    fsm_d.gsel = '0;
                end
            end
            ST_SWITCH: begin
                wr_en_o    = 1'b1;
                fsm_d.addr = fsm_q.addr + ADDR_W'(1);
                if (fsm_q.addr == LAST_GRP_A) begin
                    fsm_d.st      = ST_SETTLE;
                    fsm_d.psel    = '0;
                    settle_load_o = 1'b1;
                end else begin
                    fsm_d.gsel = fsm_q.gsel + GSEL_W'(1);
                end
            end
            ST_SETTLE: begin
                if (settle_zero_i) begin
                    fsm_d.st        = ST_CONV;
                    fsm_d.adc_start = 1'b1;
                end
            end
            ST_CONV: begin
                if (adc_done_i) begin
                    wr_en_o   = 1'b1;
                    wr_data_o = adc_data_i;
                    if (fsm_q.addr == LAST_SLOT_A) begin
                        fsm_d.st   = ST_IDLE;
                        fsm_d.done = 1'b1;
                    end else begin
                        fsm_d.st      = ST_SETTLE;
                        fsm_d.addr    = fsm_q.addr + ADDR_W'(1);
                        fsm_d.psel    = fsm_q.psel + PSEL_W'(1);
                        settle_load_o = 1'b1;
                    end
                end
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: ST_IDLE, default: '0};
        else        fsm_q <= fsm_d;
    end

    assign grp_sel_o   = fsm_q.gsel;
    assign pot_sel_o   = fsm_q.psel;
    assign adc_start_o = fsm_q.adc_start;
    assign busy_o      = (fsm_q.st != ST_IDLE);
    assign done_o      = fsm_q.done;
    assign wr_addr_o   = fsm_q.addr;

    // R6: conversion start lasts exactly one cycle
    assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |=> !adc_start_o);

    // R2: no conversion is started outside a scan
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !adc_start_o);

    // R7: the multiplexer select is held while a conversion is pending
    assert_mux_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_CONV) |-> $stable(pot_sel_o));

    // R8: completion pulse is single and coincides with idle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o ##1 !done_o));

    // R10: a scan in progress cannot be restarted
    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && fsm_q.st != ST_IDLE && fsm_q.addr != '0) |=> (fsm_q.addr != '0 || !busy_o));

endmodule

// File: rtl/scan_snap_regs.sv
module scan_snap_regs #(
    parameter int DEPTH  = 20,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        always_comb begin
            mem_d[e] = mem_q[e];
            if (wr_en_i && wr_addr_i == ADDR_W'(e)) begin
                mem_d[e] = wr_data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[e] <= '0;
            else        mem_q[e] <= mem_d[e];
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i < DEPTH_A) begin
            rd_data_o = mem_q[rd_addr_i];
        end
    end

    // R4: the sequencer only ever writes slots inside the map
    assert_wr_in_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (wr_addr_i < DEPTH_A));

    // R9: a slot that is not written keeps its value
    assert_slot_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && rd_addr_i < DEPTH_A) |=> (rd_data_o == $past(rd_data_o) || rd_addr_i != $past(rd_addr_i)));

endmodule

// File: rtl/console_scan_seq.sv
module console_scan_seq
    import ctl_scan_pkg::*;
#(
    parameter int N_GRP    = DEF_GROUPS,
    parameter int N_POT    = DEF_POTS,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int SETTLE_W = DEF_SETTLE_W,
    localparam int DEPTH   = N_GRP + N_POT,
    localparam int ADDR_W  = $clog2(DEPTH),
    localparam int GSEL_W  = (N_GRP > 1) ? $clog2(N_GRP) : 1,
    localparam int PSEL_W  = (N_POT > 1) ? $clog2(N_POT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SETTLE_W-1:0] settle_i,
    output logic [GSEL_W-1:0]   sw_grp_sel_o,
    input  logic [DATA_W-1:0]   sw_data_i,
    output logic [PSEL_W-1:0]   pot_sel_o,
    output logic                adc_start_o,
    input  logic                adc_done_i,
    input  logic [DATA_W-1:0]   adc_data_i,
    output logic                busy_o,
    output logic                done_o,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [DATA_W-1:0]   rd_data_o
);

    logic              settle_load;
    logic              settle_zero;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    scan_settle_timer #(
        .CNT_W (SETTLE_W)
    ) settle_i0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (settle_load),
        .load_val_i (settle_i),
        .zero_o     (settle_zero)
    );

    scan_seq_fsm #(
        .N_GRP  (N_GRP),
        .N_POT  (N_POT),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .GSEL_W (GSEL_W),
        .PSEL_W (PSEL_W)
    ) fsm_i0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .sw_data_i     (sw_data_i),
        .adc_done_i    (adc_done_i),
        .adc_data_i    (adc_data_i),
        .settle_zero_i (settle_zero),
        .settle_load_o (settle_load),
        .grp_sel_o     (sw_grp_sel_o),
        .pot_sel_o     (pot_sel_o),
        .adc_start_o   (adc_start_o),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .wr_en_o       (wr_en),
        .wr_addr_o     (wr_addr),
        .wr_data_o     (wr_data)
    );

    scan_snap_regs #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) regs_i0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: tb/console_scan_seq_tb_top.sv
module console_scan_seq_tb_top;

    localparam int NG    = 4;
    localparam int NP    = 16;
    localparam int DEPTH = NG + NP;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] settle_i = '0;
    logic [1:0] sw_grp_sel_o;
    logic [7:0] sw_data_i;
    logic [3:0] pot_sel_o;
    logic       adc_start_o;
    logic       adc_done_i = 1'b0;
    logic [7:0] adc_data_i = '0;
    logic       busy_o;
    logic       done_o;
    logic [4:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;

    logic [31:0] sw_bits = '0;
    logic [7:0]  pot_val [NP];
    logic [7:0]  exp_mem [DEPTH];

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    console_scan_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .settle_i     (settle_i),
        .sw_grp_sel_o (sw_grp_sel_o),
        .sw_data_i    (sw_data_i),
        .pot_sel_o    (pot_sel_o),
        .adc_start_o  (adc_start_o),
        .adc_done_i   (adc_done_i),
        .adc_data_i   (adc_data_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .rd_addr_i    (rd_addr_i),
        .rd_data_o    (rd_data_o)
    );

    // external switch selector
    assign sw_data_i = sw_bits[8*sw_grp_sel_o +: 8];

    // converter model with random latency
    initial begin
        forever begin
            @(negedge clk);
            if (adc_start_o) begin
                automatic logic [7:0] v = pot_val[pot_sel_o];
                repeat ($urandom_range(1, 6)) @(negedge clk);
                adc_data_i = v;
                adc_done_i = 1'b1;
                @(negedge clk);
                adc_done_i = 1'b0;
                adc_data_i = $urandom_range(0, 255);
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    function automatic logic [7:0] exp_slot(int a);
        if (a < NG) return sw_bits[8*a +: 8];
        return pot_val[a-NG];
    endfunction

    task automatic check_map(string req);
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr_i = 5'(a);
            #1;
            chk(req, rd_data_o, exp_mem[a]);
        end
    endtask

    // mode 0 plain, 1 read/write collision, 2 start injected mid-scan
    task automatic run_scan(int s, int mode);
        int gap = 0;
        int starts = 0;
        int dones = 0;
        int iter = 0;
        bit seen = 0;
        bit busy_bad = 0;
        sw_bits = $urandom;
        for (int k = 0; k < NP; k++) pot_val[k] = 8'($urandom_range(0, 255));
        settle_i = 8'(s);
        if (mode == 1) rd_addr_i = 5'd0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 busy after start", busy_o, 1);
        forever begin
            if (mode == 1 && iter == 0) begin
                chk("R9 slot 0 old value during its write", rd_data_o, exp_mem[0]);
            end
            if (mode == 1 && iter == 1) begin
                chk("R9 slot 0 new value after write", rd_data_o, sw_bits[7:0]);
                rd_addr_i = 5'(DEPTH - 1);
                #1;
                chk("R9 unscanned pot keeps old value", rd_data_o, exp_mem[DEPTH-1]);
            end
            if (mode == 2 && iter == 10) start_i = 1'b1;
            if (mode == 2 && iter == 11) start_i = 1'b0;
            if (done_o) begin
                dones++;
                chk("R8 busy low with done", busy_o, 0);
                break;
            end
            if (!busy_o) busy_bad = 1;
            if (adc_start_o) begin
                starts++;
                seen = 1;
            end else if (!seen) begin
                gap++;
            end
            iter++;
            if (iter > 5000) begin
                chk("watchdog scan", 0, 1);
                break;
            end
            @(negedge clk);
        end
        chk("R2 busy held during scan", busy_bad, 0);
        chk("R5 cycles before first conversion", gap, s + 5);
        chk("R6 conversions per scan", starts, NP);
        @(negedge clk);
        chk("R8 done single pulse", done_o, 0);
        repeat (3) @(negedge clk);
        if (mode == 2) chk("R10 start while busy ignored", busy_o, 0);
        for (int a = 0; a < DEPTH; a++) exp_mem[a] = exp_slot(a);
        check_map(a_req(mode));
    endtask

    function automatic string a_req(int mode);
        if (mode == 2) return "R10 map after ignored start";
        return "R3 R4 R7 map contents";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        chk("watchdog global", 0, 1);
        report();
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        for (int k = 0; k < NP; k++) pot_val[k] = '0;
        for (int a = 0; a < DEPTH; a++) exp_mem[a] = '0;
        repeat (3) @(negedge clk);
        chk("R1 busy at reset", busy_o, 0);
        chk("R1 done at reset", done_o, 0);
        chk("R1 adc start at reset", adc_start_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_map("R1 map cleared");
        run_scan(0, 0);
        run_scan(3, 1);
        run_scan(7, 2);
        sw_bits = 32'hFFFF_FFFF;
        run_scan(1, 0);
        for (int r = 0; r < 5; r++) run_scan($urandom_range(0, 12), r % 3);
        rd_addr_i = 5'd20;
        #1;
        chk("R11 address 20 reads zero", rd_data_o, 0);
        rd_addr_i = 5'd31;
        #1;
        chk("R11 address 31 reads zero", rd_data_o, 0);
        report();
    end

endmodule